// File: doc/BRIEF.md
# Byte-Split Disk Word Bridge

This block lets a CPU with an 8-bit data bus move full 16-bit words to and from a parallel disk data port, so that both bytes of every disk word are used. The lower byte of a disk word travels straight between the CPU bus and the disk bus. The upper byte is parked in a holding register, and each transfer direction has its own register. Every disk word therefore costs the CPU two accesses. One access goes to the upper-byte register. The other goes to the lower-byte path, and that second access is the one that strobes the disk.

For a disk write, the CPU stores the upper byte first. It then writes the lower byte, which puts the complete word on the disk bus for one strobe cycle. For a disk read, the CPU reads the lower byte, which pulses the disk read strobe. The low byte comes back to the CPU and the high byte is captured at the same moment. A later upper-byte read then returns the captured byte. Both buses use split data paths with enables rather than tri-state pins, and an enable is raised only while its side is driving.

The CPU side is synchronous. A single-cycle `acc_rd` or `acc_wr` pulse with `acc_cs` high is sampled on a rising clock edge. `acc_sel` picks the target: 0 selects the lower-byte path and 1 selects the upper-byte register.

Top module: `ddb_bridge`

## Requirements
- R1: During and after reset, every output is zero, and an upper-byte read made before any disk read returns 0x00.
- R2: A write with `acc_sel`=1 stores the byte in the write holding register and causes no disk strobe and no CPU read response.
- R3: A write with `acc_sel`=0 sampled at edge k raises `dsk_wr_stb` and `dsk_wdata_oe` for exactly the cycle after edge k, with `dsk_wdata` = {held upper byte, written byte}, upper byte in bits 15:8.
- R4: The write holding register keeps its value across lower-byte writes, so several disk words can share one upper byte.
- R5: A read with `acc_sel`=0 sampled at edge k raises `dsk_rd_stb` for the cycle after edge k. At edge k+1 the block samples `dsk_rdata`, and in the following cycle it drives `acc_rdata_oe`=1 with `acc_rdata` = `dsk_rdata[7:0]`.
- R6: A read with `acc_sel`=1 sampled at edge k drives `acc_rdata_oe`=1 with the byte captured from `dsk_rdata[15:8]` by the latest disk read, in the cycle after edge k.
- R7: `acc_rdata_oe` is high only in read-response cycles, and `acc_rdata` is 0x00 whenever `acc_rdata_oe` is low.
- R8: `dsk_wdata_oe` is high only together with `dsk_wr_stb`, and `dsk_wdata` is zero whenever `dsk_wr_stb` is low.
- R9: Any access sampled while `dsk_rd_stb` is high is ignored, and the pending read still completes.
- R10: An access with `acc_cs` low, or with `acc_rd` and `acc_wr` both high, is ignored.
- R11: The two directions are independent: a disk read leaves the write holding register unchanged, and an upper-byte write leaves the read holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_cs | input | 1 | CPU access select for this block |
| acc_sel | input | 1 | 0 = lower-byte path, 1 = upper-byte register |
| acc_rd | input | 1 | CPU read pulse |
| acc_wr | input | 1 | CPU write pulse |
| acc_wdata | input | 8 | CPU write byte |
| acc_rdata | output | 8 | CPU read byte |
| acc_rdata_oe | output | 1 | CPU bus drive enable / read response |
| dsk_rdata | input | 16 | Word from the disk data bus |
| dsk_wdata | output | 16 | Word driven onto the disk data bus |
| dsk_wdata_oe | output | 1 | Disk bus drive enable |
| dsk_rd_stb | output | 1 | Disk read strobe |
| dsk_wr_stb | output | 1 | Disk write strobe |

## Verification
The hardest case to reach is an access that arrives in the single cycle in which a disk read is still in flight. Only a CPU that issues its next access back-to-back with a lower-byte read can produce it. The bench drives that second access on the very cycle the read strobe is up. It then checks two things at the ports: the pending read still delivers its low byte, and the ignored write leaves neither a disk strobe nor a change in the held upper byte. A sweep over all 256 byte values pairs the low and high halves differently in each direction, so a swapped or shared holding register shows up as a data mismatch.

// File: rtl/ddb_pkg.sv
package ddb_pkg;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } sel_e;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_WR_HI = 3'd1,
        ACC_WR_LO = 3'd2,
        ACC_RD_HI = 3'd3,
        ACC_RD_LO = 3'd4
    } acc_e;

    // Classify one sampled CPU access; conflicting or blocked accesses are dropped.
    function automatic acc_e classify(input logic cs, input logic sel,
                                      input logic rd, input logic wr,
                                      input logic busy);
        acc_e k;
        k = ACC_NONE;
        if (cs && !busy && (rd ^ wr)) begin
            if (wr) k = (sel == SEL_HI) ? ACC_WR_HI : ACC_WR_LO;
            else    k = (sel == SEL_HI) ? ACC_RD_HI : ACC_RD_LO;
        end
        return k;
    endfunction

endpackage

// File: rtl/ddb_decode.sv
module ddb_decode
    import ddb_pkg::*;
(
    input  logic cs,
    input  logic sel,
    input  logic rd,
    input  logic wr,
    input  logic busy,
    output acc_e acc
);
    always_comb begin
        acc = classify(cs, sel, rd, wr, busy);
    end
endmodule

// File: rtl/ddb_wr_path.sv
module ddb_wr_path
    import ddb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] cpu_byte,
    output logic [WORD_W-1:0] word_out,
    output logic              word_oe,
    output logic              wr_stb
);
    logic [BYTE_W-1:0] hold_hi;
    logic              stb_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_hi <= '0;
            stb_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            stb_q  <= 1'b0;
            word_q <= '0;
            case (acc)
                ACC_WR_HI: hold_hi <= cpu_byte;
                ACC_WR_LO: begin
                    stb_q  <= 1'b1;
                    word_q <= {hold_hi, cpu_byte};
                end
                default: ;
            endcase
        end
    end

    assign word_out = word_q;
    assign word_oe  = stb_q;
    assign wr_stb   = stb_q;
endmodule

// File: rtl/ddb_rd_path.sv
module ddb_rd_path
    import ddb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [WORD_W-1:0] disk_word,
    output logic              rd_stb,
    output logic              busy,
    output logic [BYTE_W-1:0] cpu_byte,
    output logic              cpu_oe
);
    logic              pend_q;
    logic [BYTE_W-1:0] cap_hi;
    logic [BYTE_W-1:0] resp_q;
    logic              oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cap_hi <= '0;
            resp_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q   <= 1'b0;
            resp_q <= '0;
            if (pend_q) begin
                pend_q <= 1'b0;
                resp_q <= disk_word[BYTE_W-1:0];
                cap_hi <= disk_word[WORD_W-1:BYTE_W];
                oe_q   <= 1'b1;
            end else begin
                case (acc)
                    ACC_RD_LO: pend_q <= 1'b1;
                    ACC_RD_HI: begin
                        resp_q <= cap_hi;
                        oe_q   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_stb   = pend_q;
    assign busy     = pend_q;
    assign cpu_byte = resp_q;
    assign cpu_oe   = oe_q;
endmodule

// File: rtl/ddb_bridge.sv
module ddb_bridge
    import ddb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_cs,
    input  logic              acc_sel,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic              acc_rdata_oe,
    input  logic [WORD_W-1:0] dsk_rdata,
    output logic [WORD_W-1:0] dsk_wdata,
    output logic              dsk_wdata_oe,
    output logic              dsk_rd_stb,
    output logic              dsk_wr_stb
);
    acc_e acc;
    logic busy;

    ddb_decode u_dec (
        .cs   (acc_cs),
        .sel  (acc_sel),
        .rd   (acc_rd),
        .wr   (acc_wr),
        .busy (busy),
        .acc  (acc)
    );

    ddb_wr_path #(.BYTE_W(BYTE_W)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .cpu_byte (acc_wdata),
        .word_out (dsk_wdata),
        .word_oe  (dsk_wdata_oe),
        .wr_stb   (dsk_wr_stb)
    );

    ddb_rd_path #(.BYTE_W(BYTE_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .disk_word (dsk_rdata),
        .rd_stb    (dsk_rd_stb),
        .busy      (busy),
        .cpu_byte  (acc_rdata),
        .cpu_oe    (acc_rdata_oe)
    );
endmodule

// File: rtl/ddb_bridge_chk.sv
module ddb_bridge_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_cs,
    input logic              acc_sel,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic [BYTE_W-1:0] acc_wdata,
    input logic [BYTE_W-1:0] acc_rdata,
    input logic              acc_rdata_oe,
    input logic [WORD_W-1:0] dsk_wdata,
    input logic              dsk_wdata_oe,
    input logic              dsk_rd_stb,
    input logic              dsk_wr_stb
);
    logic lo_wr, lo_rd, hi_rd;
    assign lo_wr = acc_cs && acc_wr && !acc_rd && !acc_sel && !dsk_rd_stb;
    assign lo_rd = acc_cs && acc_rd && !acc_wr && !acc_sel && !dsk_rd_stb;
    assign hi_rd = acc_cs && acc_rd && !acc_wr &&  acc_sel && !dsk_rd_stb;

    a_r3_low_write_strobes: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (dsk_wr_stb && dsk_wdata[BYTE_W-1:0] == $past(acc_wdata)));

    a_r3_write_strobe_single: assert property (@(posedge clk) disable iff (rst)
        dsk_wr_stb |=> !dsk_wr_stb);

    a_r5_low_read_strobes: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> dsk_rd_stb);

    a_r5_read_responds: assert property (@(posedge clk) disable iff (rst)
        dsk_rd_stb |=> (acc_rdata_oe && !dsk_rd_stb));

    a_r6_high_read_responds: assert property (@(posedge clk) disable iff (rst)
        hi_rd |=> acc_rdata_oe);

    a_r7_idle_cpu_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !acc_rdata_oe |-> (acc_rdata == '0));

    a_r8_idle_disk_bus: assert property (@(posedge clk) disable iff (rst)
        !dsk_wr_stb |-> (dsk_wdata == '0 && !dsk_wdata_oe));

    a_r9_no_write_while_reading: assert property (@(posedge clk) disable iff (rst)
        dsk_rd_stb |=> !dsk_wr_stb);

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dsk_rd_stb && dsk_wr_stb));
endmodule

bind ddb_bridge ddb_bridge_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_cs       (acc_cs),
    .acc_sel      (acc_sel),
    .acc_rd       (acc_rd),
    .acc_wr       (acc_wr),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .acc_rdata_oe (acc_rdata_oe),
    .dsk_wdata    (dsk_wdata),
    .dsk_wdata_oe (dsk_wdata_oe),
    .dsk_rd_stb   (dsk_rd_stb),
    .dsk_wr_stb   (dsk_wr_stb)
);

// File: tb/tb_ddb_bridge.sv
module tb_ddb_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_cs = 0, acc_sel = 0, acc_rd = 0, acc_wr = 0;
    logic [7:0]  acc_wdata = 0;
    logic [7:0]  acc_rdata;
    logic        acc_rdata_oe;
    logic [15:0] dsk_rdata = 0;
    logic [15:0] dsk_wdata;
    logic        dsk_wdata_oe, dsk_rd_stb, dsk_wr_stb;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    ddb_bridge dut (
        .clk(clk), .rst(rst), .acc_cs(acc_cs), .acc_sel(acc_sel),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rdata_oe(acc_rdata_oe),
        .dsk_rdata(dsk_rdata), .dsk_wdata(dsk_wdata),
        .dsk_wdata_oe(dsk_wdata_oe), .dsk_rd_stb(dsk_rd_stb),
        .dsk_wr_stb(dsk_wr_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act,
                          input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // Called at a falling edge; drives one access for one clock, returns at the next falling edge.
    task automatic access(input bit cs, input bit sel, input bit rd,
                          input bit wr, input logic [7:0] d);
        acc_cs = cs; acc_sel = sel; acc_rd = rd; acc_wr = wr; acc_wdata = d;
        @(negedge clk);
        acc_cs = 0; acc_sel = 0; acc_rd = 0; acc_wr = 0; acc_wdata = 0;
    endtask

    task automatic idle;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < LIMIT; c++) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", LIMIT, LIMIT);
        finish_run();
    end

    initial begin
        logic [7:0] hi, lo, rh, rl;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk_eq("R1 outputs in reset", {acc_rdata, acc_rdata_oe, dsk_wdata,
               dsk_wdata_oe, dsk_rd_stb, dsk_wr_stb}, 32'd0);
        rst = 0;
        idle();
        access(1, 1, 1, 0, 8'h00);
        chk_eq("R1 upper read after reset", {acc_rdata_oe, acc_rdata}, {1'b1, 8'h00});
        idle();

        // R2/R3/R4/R5/R6/R11 sweep across every byte value
        for (int i = 0; i < 256; i++) begin
            hi = i[7:0]; lo = ~i[7:0];
            access(1, 1, 0, 1, hi);
            chk_eq("R2 upper write is silent", {dsk_wr_stb, dsk_rd_stb, acc_rdata_oe}, 3'b000);
            access(1, 0, 0, 1, lo);
            chk_eq("R3 word on disk", {dsk_wr_stb, dsk_wdata_oe, dsk_wdata}, {2'b11, hi, lo});
            idle();
            chk_eq("R3 strobe one cycle", {dsk_wr_stb, dsk_wdata_oe, dsk_wdata}, 18'd0);

            rl = i[7:0] + 8'd3; rh = i[7:0] ^ 8'hA5;
            dsk_rdata = {rh, rl};
            access(1, 0, 1, 0, 8'h00);
            chk_eq("R5 read strobe", {dsk_rd_stb, acc_rdata_oe}, 2'b10);
            idle();
            chk_eq("R5 low byte returned", {dsk_rd_stb, acc_rdata_oe, acc_rdata}, {2'b01, rl});
            dsk_rdata = 16'hFFFF;
            idle();
            chk_eq("R7 response one cycle", {acc_rdata_oe, acc_rdata}, 9'd0);
            access(1, 1, 1, 0, 8'h00);
            chk_eq("R6 upper byte returned", {acc_rdata_oe, acc_rdata}, {1'b1, rh});
            idle();
            // R4/R11: write holding register survives a disk read
            access(1, 0, 0, 1, 8'h3C);
            chk_eq("R11 R4 hold kept", dsk_wdata, {hi, 8'h3C});
            idle();
        end

        // R11: upper write leaves read register alone
        dsk_rdata = 16'h7E11;
        access(1, 0, 1, 0, 8'h00); idle(); idle();
        access(1, 1, 0, 1, 8'h99);
        access(1, 1, 1, 0, 8'h00);
        chk_eq("R11 read reg untouched", acc_rdata, 8'h7E);
        idle();

        // R9: accesses during pending read are ignored
        dsk_rdata = 16'h5AC3;
        access(1, 0, 1, 0, 8'h00);
        access(1, 1, 0, 1, 8'hEE);      // lands while read strobe is high
        chk_eq("R9 read still completes", {acc_rdata_oe, acc_rdata}, {1'b1, 8'hC3});
        chk_eq("R9 no disk write", dsk_wr_stb, 1'b0);
        access(1, 0, 1, 0, 8'h00);
        access(1, 0, 0, 1, 8'h44);      // ignored low write
        chk_eq("R9 no strobe from ignored write", dsk_wr_stb, 1'b0);
        idle();
        access(1, 0, 0, 1, 8'h01);
        chk_eq("R9 hold not overwritten", dsk_wdata, {8'h99, 8'h01});
        idle();

        // R10: deselected and conflicting accesses
        access(0, 0, 0, 1, 8'h12);
        chk_eq("R10 cs low write", dsk_wr_stb, 1'b0);
        access(0, 0, 1, 0, 8'h00);
        chk_eq("R10 cs low read", dsk_rd_stb, 1'b0);
        access(1, 0, 1, 1, 8'h34);
        chk_eq("R10 rd and wr together", {dsk_rd_stb, dsk_wr_stb, acc_rdata_oe}, 3'b000);
        access(1, 1, 1, 1, 8'h56);
        chk_eq("R10 upper conflict", {acc_rdata_oe, dsk_wr_stb}, 2'b00);
        access(1, 0, 0, 1, 8'h02);
        chk_eq("R10 hold unchanged", dsk_wdata, {8'h99, 8'h02});
        idle();
        chk_eq("R8 disk bus idle", {dsk_wdata_oe, dsk_wdata}, 17'd0);

        // R1: reset mid-stream clears the read holding register
        rst = 1; idle(); idle(); rst = 0; idle();
        access(1, 1, 1, 0, 8'h00);
        chk_eq("R1 read reg after reset", {acc_rdata_oe, acc_rdata}, {1'b1, 8'h00});
        idle();
        access(1, 0, 0, 1, 8'h77);
        chk_eq("R1 write reg after reset", dsk_wdata, 16'h0077);
        idle();

        finish_run();
    end
endmodule